// File: doc/BRIEF.md
# Serial Synthesizer Configuration and Test-Output Controller

This block is the digital control section of a frequency synthesizer. A 12-bit setup word arrives one bit at a time on a serial clock and data pair. A rising edge on a load strobe copies the word into three held fields: a 7-bit feedback divide value (M), a 2-bit output divide code (N) and a 3-bit test-select code (T). A level-sensitive parallel-load input can instead take M and N straight from pins. The held M value sets a down-counter whose square-wave output models the feedback divider. The N code sets a power-of-two output divider. The T code steers one of eight internal signals onto a single test pin.

All external clock-like inputs are oversampled in one system clock domain. These inputs are the serial clock, the reference clock and the synthesized clock. Each passes through a two-stage synchronizer and is then edge-detected. One test code selects a bypass mode. In bypass, the serial clock replaces the synthesized clock as the source for the feedback counter and the output divider. The analog loop, the oscillator and the output drivers are outside this block.

Top module: `pllc_top`

## Requirements
- R1: While `rst_n` is low, and after its release, `m_cfg`, `n_cfg` and `t_cfg` are zero, and `bypass`, `fout` and `mcnt_out` are low. `test_out` is low because T=000 shows shift-register bit 11, which is cleared.
- R2: Each rising edge of `sclk` shifts `sdata` into bit 0 of a 12-bit register, and the older bits move toward bit 11. A rising edge of `sload` loads the fields as follows: T from bits 11..9, N from bits 8..7 and M from bits 6..0. In the frame, the first bit shifted is T2 and the last bit shifted is M0.
- R3: Only the rising edge of `sload` loads the fields. While `sload` is held high, further shifting does not change `m_cfg`, `n_cfg` or `t_cfg`.
- R4: While `pload` is high, `m_cfg` and `n_cfg` follow `m_pin` and `n_pin`, and `t_cfg` keeps its value. After `pload` falls, changes on the pins have no effect.
- R5: If an `sload` rising edge arrives while `pload` is high, M and N come from the pins and T comes from the shift register.
- R6: With T=000, `test_out` shows shift-register bit 11. After k further `sclk` edges it shows the k-th bit of the loaded frame, counted from 0 in shift order.
- R7: T=001 drives `test_out` to 1, and T=101 drives it to 0.
- R8: T=010 shows the reference clock divided by 2. This signal starts low after reset and toggles on each rising edge of `ref_clk`.
- R9: T=011 shows `mcnt_out`. This signal toggles once every M+1 rising edges of the counter source, so a toggle occurs on every source edge when M=0.
- R10: `fout` is the counter source divided by 1, 2, 4 or 8 for N codes 00, 01, 10 and 11. It changes every 2^(N-1) source rising edges, and for N=00 it follows the source level. T=100 shows `fout` on `test_out`.
- R11: T=110 sets `bypass` high. The counter source then becomes `sclk` instead of `synth_clk`, so `synth_clk` edges move neither `mcnt_out` nor `fout`, and `test_out` shows `mcnt_out`.
- R12: T=111 shows `fout` divided by 4. This signal starts low and toggles on every second rising edge of `fout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all other inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; rising edges shift data |
| sdata | input | 1 | Serial data, first bit T2 |
| sload | input | 1 | Load strobe, rising-edge active |
| pload | input | 1 | Parallel load enable for M and N, level active |
| m_pin | input | 7 | Parallel M value |
| n_pin | input | 2 | Parallel N code |
| ref_clk | input | 1 | Reference clock, modelled as data |
| synth_clk | input | 1 | Synthesized clock, modelled as data |
| m_cfg | output | 7 | Held feedback divide value |
| n_cfg | output | 2 | Held output divide code |
| t_cfg | output | 3 | Held test-select code |
| bypass | output | 1 | High when T=110 |
| fout | output | 1 | Divided output clock |
| mcnt_out | output | 1 | Feedback counter square wave |
| test_out | output | 1 | Selected test signal |

## Verification
The assertions take for granted that every serial, strobe and clock input stays at each level for at least three system clocks. They also assume that `sdata` settles no later than the `sclk` rise it goes with, and that `m_pin` and `n_pin` hold steady while `pload` is high. The bench meets these assumptions by driving every input on the falling system clock edge. It holds each level for six cycles and changes `sdata` two cycles before the `sclk` rise. It sets the pins before it raises `pload`.

// File: rtl/pllc_pkg.sv
// Package: shared widths and test-select encoding for the synthesizer controller.
// Assumes: the frame is T, then N, then M, most significant bit first.
package pllc_pkg;
    localparam int M_W = 7;
    localparam int N_W = 2;
    localparam int T_W = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    typedef enum logic [2:0] {
        TS_SHIFT   = 3'b000,
        TS_ONE     = 3'b001,
        TS_REFDIV2 = 3'b010,
        TS_MCOUNT  = 3'b011,
        TS_FOUT    = 3'b100,
        TS_ZERO    = 3'b101,
        TS_BYPASS  = 3'b110,
        TS_FOUTD4  = 3'b111
    } test_sel_e;
endpackage

// File: rtl/pllc_sync.sv
// Module: multi-stage level synchronizer into the system clock domain.
// Assumes: STAGES >= 2; the input is held longer than STAGES+1 clocks.
module pllc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    // Shift the raw input through the flop chain; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pllc_shift.sv
// Module: serial shift register clocked by detected rising edges of the serial clock.
// Assumes: sclk_lvl and sdata_lvl are already synchronized with equal latency.
module pllc_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_lvl,
    input  logic         sdata_lvl,
    output logic [W-1:0] frame,
    output logic         sout
);
    logic sclk_prev;
    logic shift_en;

    assign shift_en = sclk_lvl & ~sclk_prev;

    // Remember the last serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_lvl;
    end

    // Shift new data into bit 0 on each serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame <= '0;
        else if (shift_en) frame <= {frame[W-2:0], sdata_lvl};
    end

    assign sout = frame[W-1];

    // R2: the newest bit is the sampled data.
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame[0] == $past(sdata_lvl));
    // R2: without a serial clock rise the register holds.
    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame));
endmodule

// File: rtl/pllc_cfg.sv
// Module: held M/N/T configuration, loaded serially on a load-strobe rise
// or in parallel from pins while the parallel-load level is high.
// Assumes: strobes are synchronized; pins are stable while pload is high.
module pllc_cfg
    import pllc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sload_lvl,
    input  logic               pload_lvl,
    input  logic [FRAME_W-1:0] frame,
    input  logic [M_W-1:0]     m_pin,
    input  logic [N_W-1:0]     n_pin,
    output logic [M_W-1:0]     m_q,
    output logic [N_W-1:0]     n_q,
    output logic [T_W-1:0]     t_q
);
    localparam int T_LSB = N_W + M_W;
    localparam int N_LSB = M_W;

    logic sload_prev;
    logic ld_rise;

    assign ld_rise = sload_lvl & ~sload_prev;

    // Remember the last strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sload_prev <= 1'b0;
        else        sload_prev <= sload_lvl;
    end

    // Test code comes only from the shift register on a strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       t_q <= '0;
        else if (ld_rise) t_q <= frame[T_LSB +: T_W];
    end

    // Divider fields: pins win while pload is high, else the strobe loads them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
        end else if (pload_lvl) begin
            m_q <= m_pin;
            n_q <= n_pin;
        end else if (ld_rise) begin
            m_q <= frame[0 +: M_W];
            n_q <= frame[N_LSB +: N_W];
        end
    end

    // R3: no load activity means every field holds.
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_rise && !pload_lvl) |=> $stable({m_q, n_q, t_q}));
    // R4: parallel load never touches the test code.
    assert_pload_keeps_t_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_lvl && !ld_rise) |=> $stable(t_q));
    // R5: with both loads active, M and N follow the pins.
    assert_pload_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_lvl && ld_rise) |=> (m_q == $past(m_pin)) && (n_q == $past(n_pin)));
endmodule

// File: rtl/pllc_clkgen.sv
// Module: feedback down-counter, power-of-two output divider, reference /2
// and output /4 toggles, all driven by edges detected in the system clock.
// Assumes: all level inputs are synchronized; bypass selects sclk as source.
module pllc_clkgen #(
    parameter int M_W = 7,
    parameter int N_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bypass,
    input  logic           sclk_lvl,
    input  logic           synth_lvl,
    input  logic           ref_lvl,
    input  logic [M_W-1:0] m,
    input  logic [N_W-1:0] n,
    output logic           mout,
    output logic           fout,
    output logic           fout_div4,
    output logic           ref_div2
);
    localparam int DIV_W = (1 << N_W) - 1;

    logic             sclk_prev, synth_prev, ref_prev, fout_prev;
    logic             src_lvl, src_rise, ref_rise, fout_rise;
    logic [M_W-1:0]   mcnt;
    logic [DIV_W-1:0] div_cnt;
    logic [1:0]       d4_cnt;
    logic             fout_sel;

    // Store previous levels of every edge-detected signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            synth_prev <= 1'b0;
            ref_prev   <= 1'b0;
            fout_prev  <= 1'b0;
        end else begin
            sclk_prev  <= sclk_lvl;
            synth_prev <= synth_lvl;
            ref_prev   <= ref_lvl;
            fout_prev  <= fout;
        end
    end

    // Pick the counter source: serial clock in bypass, else synthesized clock.
    always_comb begin
        if (bypass) begin
            src_lvl  = sclk_lvl;
            src_rise = sclk_lvl & ~sclk_prev;
        end else begin
            src_lvl  = synth_lvl;
            src_rise = synth_lvl & ~synth_prev;
        end
    end

    assign ref_rise  = ref_lvl & ~ref_prev;
    assign fout_rise = fout & ~fout_prev;

    // Reference divide-by-2 toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_div2 <= 1'b0;
        else if (ref_rise) ref_div2 <= ~ref_div2;
    end

    // Feedback down-counter: reload from M and toggle the output at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0;
            mout <= 1'b0;
        end else if (src_rise) begin
            if (mcnt == '0) begin
                mcnt <= m;
                mout <= ~mout;
            end else begin
                mcnt <= mcnt - 1'b1;
            end
        end
    end

    // Free-running binary divider chain on source rises.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (src_rise) div_cnt <= div_cnt + 1'b1;
    end

    // Choose the divider tap named by N; code 0 passes the source level.
    always_comb begin
        fout_sel = src_lvl;
        for (int k = 1; k <= DIV_W; k++) begin
            if (n == N_W'(k)) fout_sel = div_cnt[k-1];
        end
    end

    // Register the output clock.
    always_ff @(posedge clk) begin
        if (!rst_n) fout <= 1'b0;
        else        fout <= fout_sel;
    end

    // Output divide-by-4 counter on output clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n)         d4_cnt <= '0;
        else if (fout_rise) d4_cnt <= d4_cnt + 1'b1;
    end

    assign fout_div4 = d4_cnt[1];

    // R8: the reference toggle moves only on a reference rise.
    assert_ref_div2_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_rise |=> $stable(ref_div2));
    // R9: the feedback output moves only on a source rise.
    assert_mout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_rise |=> $stable(mout));
    // R11: in bypass, synthesized clock edges alone move no counter.
    assert_bypass_ignores_synth_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !(sclk_lvl & ~sclk_prev)) |=> $stable({mout, div_cnt}));
    // R12: the /4 counter moves only on an output rise.
    assert_div4_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !fout_rise |=> $stable(d4_cnt));
endmodule

// File: rtl/pllc_top.sv
// Module: top of the synthesizer control section. It synchronizes the inputs,
// holds the configuration, generates the divided clocks and drives the test mux.
// Assumes: every asynchronous input is held for at least 3 system clocks.
module pllc_top
    import pllc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdata,
    input  logic           sload,
    input  logic           pload,
    input  logic [M_W-1:0] m_pin,
    input  logic [N_W-1:0] n_pin,
    input  logic           ref_clk,
    input  logic           synth_clk,
    output logic [M_W-1:0] m_cfg,
    output logic [N_W-1:0] n_cfg,
    output logic [T_W-1:0] t_cfg,
    output logic           bypass,
    output logic           fout,
    output logic           mcnt_out,
    output logic           test_out
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0]   raw_in, sync_lvl;
    logic [FRAME_W-1:0] frame;
    logic               sout, fout_div4, ref_div2;

    assign raw_in = {synth_clk, ref_clk, pload, sload, sdata, sclk};

    // One synchronizer per asynchronous input.
    for (genvar gi = 0; gi < NSYNC; gi++) begin : g_sync
        pllc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[gi]),
            .q     (sync_lvl[gi])
        );
    end

    pllc_shift #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_lvl  (sync_lvl[0]),
        .sdata_lvl (sync_lvl[1]),
        .frame     (frame),
        .sout      (sout)
    );

    pllc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sload_lvl (sync_lvl[2]),
        .pload_lvl (sync_lvl[3]),
        .frame     (frame),
        .m_pin     (m_pin),
        .n_pin     (n_pin),
        .m_q       (m_cfg),
        .n_q       (n_cfg),
        .t_q       (t_cfg)
    );

    assign bypass = (t_cfg == TS_BYPASS);

    pllc_clkgen #(.M_W(M_W), .N_W(N_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (bypass),
        .sclk_lvl  (sync_lvl[0]),
        .synth_lvl (sync_lvl[5]),
        .ref_lvl   (sync_lvl[4]),
        .m         (m_cfg),
        .n         (n_cfg),
        .mout      (mcnt_out),
        .fout      (fout),
        .fout_div4 (fout_div4),
        .ref_div2  (ref_div2)
    );

    // Route one internal signal to the test pin according to the test code.
    always_comb begin
        case (test_sel_e'(t_cfg))
            TS_SHIFT:   test_out = sout;
            TS_ONE:     test_out = 1'b1;
            TS_REFDIV2: test_out = ref_div2;
            TS_MCOUNT:  test_out = mcnt_out;
            TS_FOUT:    test_out = fout;
            TS_ZERO:    test_out = 1'b0;
            TS_BYPASS:  test_out = mcnt_out;
            default:    test_out = fout_div4;
        endcase
    end

    // R7: the constant codes drive the pin even when other signals move.
    assert_const_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_cfg == 3'b001 |-> test_out) and (t_cfg == 3'b101 |-> !test_out));
endmodule

// File: tb/tb_pllc_top.sv
module tb_pllc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0, pload = 1'b0;
    logic [6:0] m_pin = '0;
    logic [1:0] n_pin = '0;
    logic       ref_clk = 1'b0, synth_clk = 1'b0;
    logic [6:0] m_cfg;
    logic [1:0] n_cfg;
    logic [2:0] t_cfg;
    logic       bypass, fout, mcnt_out, test_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pllc_top dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
        .pload(pload), .m_pin(m_pin), .n_pin(n_pin), .ref_clk(ref_clk),
        .synth_clk(synth_clk), .m_cfg(m_cfg), .n_cfg(n_cfg), .t_cfg(t_cfg),
        .bypass(bypass), .fout(fout), .mcnt_out(mcnt_out), .test_out(test_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(input logic d);
        @(negedge clk); sdata = d;
        wait_n(2); sclk = 1'b1;
        wait_n(6); sclk = 1'b0;
        wait_n(6);
    endtask

    task automatic shift_frame(input logic [2:0] t, input logic [1:0] n, input logic [6:0] m);
        logic [11:0] f;
        f = {t, n, m};
        for (int i = 11; i >= 0; i--) sclk_pulse(f[i]);
    endtask

    task automatic sload_pulse();
        @(negedge clk); sload = 1'b1;
        wait_n(6); sload = 1'b0;
        wait_n(6);
    endtask

    task automatic load_frame(input logic [2:0] t, input logic [1:0] n, input logic [6:0] m);
        shift_frame(t, n, m);
        sload_pulse();
    endtask

    task automatic src_pulse(input int src);
        @(negedge clk);
        if (src == 0) synth_clk = 1'b1; else if (src == 1) sclk = 1'b1; else ref_clk = 1'b1;
        wait_n(6);
        if (src == 0) synth_clk = 1'b0; else if (src == 1) sclk = 1'b0; else ref_clk = 1'b0;
        wait_n(6);
    endtask

    function automatic logic obs_val(input int obs);
        return (obs == 0) ? test_out : fout;
    endfunction

    // Count source pulses between two successive changes of an observed output.
    task automatic measure(input int src, input int obs, output int cnt);
        logic v;
        int   k;
        v = obs_val(obs);
        k = 0;
        while (obs_val(obs) == v && k < 40) begin src_pulse(src); k++; end
        v = obs_val(obs);
        cnt = 0;
        while (obs_val(obs) == v && cnt < 40) begin src_pulse(src); cnt++; end
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R1 m_cfg in reset", m_cfg, 0);
        rst_n = 1'b1;
        wait_n(4);
        check("R1 m_cfg", m_cfg, 0);
        check("R1 n_cfg", n_cfg, 0);
        check("R1 t_cfg", t_cfg, 0);
        check("R1 bypass", bypass, 0);
        check("R1 fout", fout, 0);
        check("R1 mcnt_out", mcnt_out, 0);
        check("R1 test_out", test_out, 0);
    endtask

    task automatic t_serial_and_const();
        load_frame(3'b001, 2'b10, 7'h5A);
        check("R2 t field", t_cfg, 1);
        check("R2 n field", n_cfg, 2);
        check("R2 m field", m_cfg, 'h5A);
        check("R7 code 001 gives 1", test_out, 1);
        load_frame(3'b101, 2'b01, 7'h33);
        check("R2 m field second", m_cfg, 'h33);
        check("R7 code 101 gives 0", test_out, 0);
    endtask

    task automatic t_sload_edge();
        @(negedge clk); sload = 1'b1;
        wait_n(6);
        shift_frame(3'b001, 2'b11, 7'h11);
        check("R3 m held under high sload", m_cfg, 'h33);
        check("R3 t held under high sload", t_cfg, 5);
        sload = 1'b0;
        wait_n(6);
        check("R3 n held after sload falls", n_cfg, 1);
        sload_pulse();
        check("R3 m after new rise", m_cfg, 'h11);
        check("R3 t after new rise", t_cfg, 1);
    endtask

    task automatic t_pload();
        m_pin = 7'h6C; n_pin = 2'b10;
        @(negedge clk); pload = 1'b1;
        wait_n(6);
        check("R4 m follows pins", m_cfg, 'h6C);
        check("R4 n follows pins", n_cfg, 2);
        check("R4 t kept", t_cfg, 1);
        pload = 1'b0;
        wait_n(6);
        m_pin = 7'h01; n_pin = 2'b01;
        wait_n(6);
        check("R4 pins ignored after pload low", m_cfg, 'h6C);
    endtask

    task automatic t_priority();
        shift_frame(3'b101, 2'b00, 7'h7F);
        m_pin = 7'h22; n_pin = 2'b11;
        @(negedge clk); pload = 1'b1; sload = 1'b1;
        wait_n(6);
        pload = 1'b0; sload = 1'b0;
        wait_n(6);
        check("R5 m from pins", m_cfg, 'h22);
        check("R5 n from pins", n_cfg, 3);
        check("R5 t from frame", t_cfg, 5);
    endtask

    task automatic t_serial_out();
        logic [11:0] f;
        f = {3'b000, 2'b10, 7'b1011001};
        load_frame(f[11:9], f[8:7], f[6:0]);
        for (int k = 0; k < 12; k++) begin
            check($sformatf("R6 bit %0d on test_out", k), test_out, int'(f[11-k]));
            sclk_pulse(1'b0);
        end
    endtask

    task automatic t_ref_div2();
        load_frame(3'b010, 2'b00, 7'd0);
        check("R8 ref/2 starts low", test_out, 0);
        src_pulse(2); check("R8 after 1 ref edge", test_out, 1);
        src_pulse(2); check("R8 after 2 ref edges", test_out, 0);
        src_pulse(2); check("R8 after 3 ref edges", test_out, 1);
    endtask

    task automatic t_mcount();
        int c;
        load_frame(3'b011, 2'b00, 7'd4);
        measure(0, 0, c); check("R9 M=4 edges per toggle", c, 5);
        measure(0, 0, c); check("R9 M=4 second period", c, 5);
        load_frame(3'b011, 2'b00, 7'd0);
        measure(0, 0, c); check("R9 M=0 edges per toggle", c, 1);
    endtask

    task automatic t_fout();
        int c;
        load_frame(3'b100, 2'b00, 7'd3);
        @(negedge clk); synth_clk = 1'b1; wait_n(6);
        check("R10 N=0 follows high", test_out, 1);
        check("R10 fout port high", fout, 1);
        synth_clk = 1'b0; wait_n(6);
        check("R10 N=0 follows low", test_out, 0);
        load_frame(3'b100, 2'b01, 7'd3);
        measure(0, 0, c); check("R10 N=1 edges per change", c, 1);
        load_frame(3'b100, 2'b10, 7'd3);
        measure(0, 0, c); check("R10 N=2 edges per change", c, 2);
        load_frame(3'b100, 2'b11, 7'd3);
        measure(0, 1, c); check("R10 N=3 edges per change", c, 4);
    endtask

    task automatic t_fout_div4();
        int c;
        load_frame(3'b111, 2'b00, 7'd0);
        measure(0, 0, c); check("R12 fout/4 edges per change", c, 2);
        measure(0, 0, c); check("R12 fout/4 second half", c, 2);
    endtask

    task automatic t_bypass();
        int  c;
        logic t0, f0;
        load_frame(3'b110, 2'b01, 7'd2);
        check("R11 bypass high", bypass, 1);
        measure(1, 0, c); check("R11 mcnt on test_out via sclk", c, 3);
        measure(1, 1, c); check("R11 fout from sclk N=1", c, 1);
        t0 = test_out; f0 = fout;
        for (int i = 0; i < 8; i++) src_pulse(0);
        check("R11 synth ignored on mcnt", test_out, t0);
        check("R11 synth ignored on fout", fout, f0);
        load_frame(3'b000, 2'b00, 7'd0);
        check("R11 bypass cleared", bypass, 0);
    endtask

    initial begin
        t_reset();
        t_serial_and_const();
        t_sload_edge();
        t_pload();
        t_priority();
        t_serial_out();
        t_ref_div2();
        t_mcount();
        t_fout();
        t_fout_div4();
        t_bypass();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule